// File: doc/BRIEF.md
# CSR Bus Timeout Responder

This block is a passive listener on a shared, pipelined register-access bus. The bus master raises a request and holds it until some target acknowledges it. Every target's response is OR-ed onto a common response bus. The responder watches the request together with the combined acknowledge from all other targets. It counts the consecutive cycles in which a request is pending and no target has answered. If that count reaches a programmable limit, the responder answers the request itself, so a request that no target claims still completes and the master cannot stall forever.

A write that times out gets only an acknowledge. A read that times out gets the acknowledge plus a read-data-valid strobe with the error flag set and all-zero data. The master can then tell a missing target apart from a genuine zero read. The responder drives only zeros when it is not answering, so its outputs can be OR-ed with any other target's response. A limit of zero switches the responder off.

Top module: `csr_bus_timeout_responder`

## Requirements
- R1: While reset is high, and in the first cycle after reset, every response output (ack, read-valid, read-error, read data) is zero.
- R2: A request that is pending (valid high, combined bus acknowledge low) for `limit` consecutive rising edges gets `rsp_ack` high right after the `limit`-th of those edges.
- R3: Before the `limit`-th pending edge, `rsp_ack` stays low.
- R4: If the combined bus acknowledge rises before the limit is reached, the responder never acknowledges that request.
- R5: A timed-out read (`req_rd` = 1) drives `rsp_rd_valid` = 1, `rsp_rd_err` = 1 and `rsp_rd_data` = 0 for as long as `rsp_ack` is high.
- R6: A timed-out write (`req_rd` = 0) drives `rsp_ack` only, with `rsp_rd_valid` and `rsp_rd_err` at 0.
- R7: Once the auto-acknowledge is high, it stays high for as long as `req_valid` stays high.
- R8: After the first rising edge at which `req_valid` is low, all response outputs are zero.
- R9: When `limit` is zero, the responder never acknowledges, however long a request waits.
- R10: The count starts again from zero for every new request. A request that follows a timed-out one waits the full `limit` again.
- R11: The largest limit, 16'hFFFF, times out after exactly 65535 pending edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid from the bus master |
| req_rd | input | 1 | 1 = read request, 0 = write request |
| bus_ack | input | 1 | OR of every other target's acknowledge |
| limit | input | 16 | Number of pending cycles to wait before auto-acknowledging; 0 disables |
| rsp_ack | output | 1 | Auto-acknowledge, OR-able onto the response bus |
| rsp_rd_valid | output | 1 | Read data valid for a timed-out read |
| rsp_rd_err | output | 1 | Read error flag for a timed-out read |
| rsp_rd_data | output | 32 | Read data, always zero |

## Verification
The bench uses the default widths: a 16-bit count and 32-bit read data. Because the count is 16 bits, the bench can run the full limit of 65535 cycles in one run and check the exact edge at which the largest window expires. Random limits from 1 to 12 are mixed with a competing target that answers at a random earlier cycle. This exercises both winners of the race at small widths, plus back-to-back requests and the disabled setting.

// File: rtl/csr_tmo_pkg.sv
package csr_tmo_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned DATA_W = 32;

    // Latched answer state of the responder
    typedef struct packed {
        logic held;   // auto-acknowledge asserted
        logic rd;     // answered request was a read
    } tmo_state_t;

    localparam tmo_state_t TMO_IDLE = '{held: 1'b0, rd: 1'b0};

    // True once the pending count including this cycle reaches the limit
    function automatic logic window_done(input logic [CNT_W-1:0] cnt,
                                         input logic [CNT_W-1:0] lim);
        logic [CNT_W:0] nxt;
        nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        return (lim != '0) && (nxt >= {1'b0, lim});
    endfunction

endpackage

// File: rtl/csr_tmo_counter.sv
module csr_tmo_counter
    import csr_tmo_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pending,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    assign expire = pending && window_done(cnt_q, limit);

    always_ff @(posedge clk) begin
        if (rst || !pending) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/csr_tmo_reply.sv
module csr_tmo_reply
    import csr_tmo_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_rd,
    input  logic          expire,
    output logic          ack,
    output logic          rd_valid,
    output logic          rd_err,
    output logic [DW-1:0] rd_data
);
    tmo_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            st_q <= TMO_IDLE;
        end else if (expire) begin
            st_q <= '{held: 1'b1, rd: req_rd};
        end
    end

    assign ack      = st_q.held;
    assign rd_valid = st_q.held && st_q.rd;
    assign rd_err   = st_q.held && st_q.rd;
    assign rd_data  = '0;
endmodule

// File: rtl/csr_bus_timeout_responder.sv
module csr_bus_timeout_responder
    import csr_tmo_pkg::*;
#(
    parameter int unsigned CW = CNT_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_rd,
    input  logic          bus_ack,
    input  logic [CW-1:0] limit,
    output logic          rsp_ack,
    output logic          rsp_rd_valid,
    output logic          rsp_rd_err,
    output logic [DW-1:0] rsp_rd_data
);
    logic pending;
    logic expire;

    assign pending = req_valid && !bus_ack && !rsp_ack;

    csr_tmo_counter #(.W(CW)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .limit   (limit),
        .expire  (expire)
    );

    csr_tmo_reply #(.DW(DW)) u_reply (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_rd    (req_rd),
        .expire    (expire),
        .ack       (rsp_ack),
        .rd_valid  (rsp_rd_valid),
        .rd_err    (rsp_rd_err),
        .rd_data   (rsp_rd_data)
    );
endmodule

// File: rtl/csr_bus_timeout_responder_chk.sv
module csr_bus_timeout_responder_chk #(
    parameter int unsigned CW = 16,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          bus_ack,
    input logic [CW-1:0] limit,
    input logic          rsp_ack,
    input logic          rsp_rd_valid,
    input logic          rsp_rd_err,
    input logic [DW-1:0] rsp_rd_data
);
    // R7
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_ack && req_valid |=> rsp_ack);

    // R8
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_ack && !rsp_rd_valid && !rsp_rd_err);

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (limit == '0) && !rsp_ack |=> !rsp_ack);

    // R4
    ack_only_unclaimed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_ack) |-> $past(req_valid && !bus_ack));

    // R5
    rd_flags_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_rd_valid |-> rsp_ack && rsp_rd_err && (rsp_rd_data == '0));

    // R6
    err_pairs_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_rd_err |-> rsp_rd_valid);
endmodule

bind csr_bus_timeout_responder csr_bus_timeout_responder_chk #(.CW(CW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .bus_ack      (bus_ack),
    .limit        (limit),
    .rsp_ack      (rsp_ack),
    .rsp_rd_valid (rsp_rd_valid),
    .rsp_rd_err   (rsp_rd_err),
    .rsp_rd_data  (rsp_rd_data)
);

// File: tb/csr_bus_timeout_responder_bench.sv
module csr_bus_timeout_responder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_rd = 1'b0;
    logic        bus_ack = 1'b0;
    logic [15:0] limit = 16'd0;
    logic        rsp_ack;
    logic        rsp_rd_valid;
    logic        rsp_rd_err;
    logic [31:0] rsp_rd_data;

    int checks = 0;
    int failures = 0;
    int seed = 32'h5EED_0017;
    bit done = 1'b0;

    always #5 clk = ~clk;

    csr_bus_timeout_responder u_csr_bus_timeout_responder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_rd(req_rd),
        .bus_ack(bus_ack), .limit(limit), .rsp_ack(rsp_ack),
        .rsp_rd_valid(rsp_rd_valid), .rsp_rd_err(rsp_rd_err),
        .rsp_rd_data(rsp_rd_data)
    );

    // Packs the response into {ack, rd_valid, rd_err, data==0}
    function automatic logic [3:0] want_rsp(input bit acked, input bit rd);
        return {acked, acked && rd, acked && rd, 1'b1};
    endfunction

    function automatic logic [3:0] got_rsp();
        return {rsp_ack, rsp_rd_valid, rsp_rd_err, rsp_rd_data == 32'd0};
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One request; other_at = 0 means no other target answers
    task automatic run_req(input int lim, input bit rd, input int other_at, input string tag);
        bit expect_tmo;
        bit early;
        expect_tmo = (lim != 0) && (other_at == 0 || other_at >= lim);
        limit = lim[15:0];
        req_rd = rd;
        req_valid = 1'b1;
        early = 1'b0;
        if (expect_tmo) begin
            for (int k = 1; k < lim; k++) begin
                tick();
                if (rsp_ack) early = 1'b1;
            end
            // R3
            check({tag, " R3 no early ack"}, {3'b000, early}, 4'b0000);
            tick();
            // R2, R5, R6
            check({tag, rd ? " R2 R5 read timeout" : " R2 R6 write timeout"}, got_rsp(), want_rsp(1'b1, rd));
            for (int k = 0; k < 3; k++) tick();
            // R7
            check({tag, " R7 hold"}, got_rsp(), want_rsp(1'b1, rd));
        end else begin
            for (int k = 1; k <= ((lim == 0) ? 40 : lim + 3); k++) begin
                tick();
                if (rsp_ack) early = 1'b1;
                if (k == other_at) bus_ack = 1'b1;
            end
            // R4, R9
            check({tag, (lim == 0) ? " R9 disabled" : " R4 other target wins"}, {3'b000, early}, 4'b0000);
        end
        req_valid = 1'b0;
        bus_ack = 1'b0;
        tick();
        // R8
        check({tag, " R8 release"}, got_rsp(), want_rsp(1'b0, 1'b0));
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(seed));
        limit = 16'd3;
        req_valid = 1'b1;
        repeat (3) tick();
        // R1
        check("R1 outputs in reset", got_rsp(), want_rsp(1'b0, 1'b0));
        rst = 1'b0;
        req_valid = 1'b0;
        tick();
        check("R1 outputs after reset", got_rsp(), want_rsp(1'b0, 1'b0));

        run_req(1, 1'b1, 0, "lim1 read");
        run_req(1, 1'b0, 0, "lim1 write");
        run_req(5, 1'b1, 0, "lim5 read");
        // R10: back-to-back with the same limit waits the full window again
        run_req(5, 1'b0, 0, "R10 second request");
        run_req(6, 1'b1, 5, "other at lim-1");
        run_req(4, 1'b0, 1, "other at 1");
        run_req(0, 1'b1, 0, "zero limit");

        for (int n = 0; n < 20; n++) begin
            int lim;
            int oth;
            lim = 1 + int'($urandom_range(11));
            oth = ($urandom_range(2) == 0) ? 0 : 1 + int'($urandom_range(14));
            run_req(lim, 1'($urandom_range(1)), oth, "random");
        end

        // R11
        run_req(65535, 1'b1, 0, "R11 max limit");

        done = 1'b1;
        summary();
    end
endmodule